// File: doc/BRIEF.md
# Serial Sigma-Delta Converter Read Controller

This block is the host side of a link to a serial sigma-delta analog-to-digital converter. It drives two frame-select lines, a register-select line, a serial clock and a 3-bit channel code. It listens on one shared input that carries the converter's busy/ready status between frames and the conversion bits inside a read frame. After the converter has been configured (the configuration write is done elsewhere), the controller waits until the converter reports ready. It then reads each new conversion result MSB first, in either 24-bit or 16-bit length, and presents the result as a parallel word with a one-cycle strobe.

When the requested channel differs from the one being driven, the controller switches the channel code only while no frame is open. It then drops the first result that completes after the switch, because that conversion may mix the old and new inputs. The serial clock comes from the system clock. Each high phase and each low phase lasts a parameter number of system cycles.

Top module: `sdadc_reader`

## Requirements
- R1: While reset is high and in the first cycle after it, both frame selects and the status line are high, the register select and serial clock are low, the channel code is 000 and the strobe is low.
- R2: The transmit frame select stays high at all times. The controller never opens a write frame and never issues a mode-restore write after calibration.
- R3: A read frame may start only in the polling state, with the receive frame select high and the shared input sampled low. While that input is sampled high, the controller keeps polling and opens no frame.
- R4: A frame opens with the register select going high for HALF_CYC cycles while the receive frame select is still high. The receive frame select then goes low. The register select stays high whenever the receive frame select is low.
- R5: Each bit is one serial clock period: HALF_CYC cycles high, then HALF_CYC cycles low. The shared input is sampled in the last system cycle of the high phase, and the first bit sampled becomes the word's MSB.
- R6: The frame holds 24 clock periods when `wide_i` is 1 at frame start and 16 when it is 0. `wide_i` is latched at frame start, so changes during a frame have no effect on it.
- R7: After the last low phase, the receive frame select returns high. The register select stays high for HALF_CYC more cycles and then returns low as polling resumes.
- R8: A 16-bit result is placed right-justified in the 24-bit output with bits 23..16 zero.
- R9: `res_vld_o` is a single-cycle pulse in the first polling cycle after a reported frame. It carries the word and the channel code the frame was read on.
- R10: The channel code is plain binary, 000 for channel 1 up to 111 for channel 8. It takes the value of `chan_i` only in a polling cycle where the two differ, and it never changes while a frame is open.
- R11: The first frame that completes after any channel change is read but not reported: no strobe, and the output word keeps its old value. Later frames are reported. Several changes before one frame cost only that one frame.
- R12: With `run_i` low, the controller goes from polling to idle and opens no frame. It resumes polling in the cycle after `run_i` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Enables polling and reading |
| chan_i | input | CHAN_W | Requested channel code |
| wide_i | input | 1 | 1 selects 24-bit frames, 0 selects 16-bit |
| sdi_i | input | 1 | Shared status / serial data from converter |
| tfs_o | output | 1 | Transmit frame select, active low |
| rfs_o | output | 1 | Receive frame select, active low |
| cd_o | output | 1 | Register select, high for data register |
| sclk_o | output | 1 | Serial clock |
| chs_o | output | CHAN_W | Channel code driven to the converter |
| res_o | output | WORD_W | Last reported result |
| res_chan_o | output | CHAN_W | Channel code of the last reported result |
| res_vld_o | output | 1 | One-cycle strobe for a reported result |

## Verification
The bench builds the block with HALF_CYC = 2 and with the default 24/16-bit and 3-bit channel widths. A short half period keeps a full 24-bit frame near one hundred cycles. That leaves room for a calibration wait, runs of frames in both word lengths, a single and a double channel change, and a stop-and-restart of `run_i`, all against a converter model whose busy time separates the frames. Because HALF_CYC is above one, the phase counter actually wraps, and the bench can tell apart a sample taken in the last high cycle from one taken in the first.

// File: rtl/sdadc_pkg.sv
`timescale 1ns/1ps
package sdadc_pkg;

    // Sequencer states; the frame states form the read sequence in order.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_POLL  = 3'd1,
        ST_SEL   = 3'd2,
        ST_HIGH  = 3'd3,
        ST_LOW   = 3'd4,
        ST_CLOSE = 3'd5
    } seq_state_e;

    // Pin levels produced for one sequencer state.
    typedef struct packed {
        logic rfs;
        logic cd;
        logic sclk;
    } pin_set_t;

    function automatic pin_set_t pins_for(input seq_state_e st);
        pin_set_t p;
        p = '{rfs: 1'b1, cd: 1'b0, sclk: 1'b0};
        case (st)
            ST_SEL:   p = '{rfs: 1'b1, cd: 1'b1, sclk: 1'b0};
            ST_HIGH:  p = '{rfs: 1'b0, cd: 1'b1, sclk: 1'b1};
            ST_LOW:   p = '{rfs: 1'b0, cd: 1'b1, sclk: 1'b0};
            ST_CLOSE: p = '{rfs: 1'b1, cd: 1'b1, sclk: 1'b0};
            default:  p = '{rfs: 1'b1, cd: 1'b0, sclk: 1'b0};
        endcase
        return p;
    endfunction

    function automatic bit in_frame(input seq_state_e st);
        return (st == ST_SEL) || (st == ST_HIGH) || (st == ST_LOW) || (st == ST_CLOSE);
    endfunction

endpackage

// File: rtl/sdadc_phase.sv
`timescale 1ns/1ps
module sdadc_phase #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic last_o
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last_o = (cnt_q == CNT_END);

    always_ff @(posedge clk) begin
        if (rst || restart_i || last_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    p_phase_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_END);

endmodule

// File: rtl/sdadc_capture.sv
`timescale 1ns/1ps
module sdadc_capture #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] word_q;

    assign word_o = word_q;

    // Clearing at frame start leaves short words right-justified over zeros.
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            word_q <= '0;
        end else if (shift_i) begin
            word_q <= {word_q[WORD_W-2:0], bit_i};
        end
    end

    p_clr_shift_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(clr_i && shift_i));

endmodule

// File: rtl/sdadc_seq.sv
`timescale 1ns/1ps
module sdadc_seq
    import sdadc_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 16,
    parameter int CHAN_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              wide_i,
    input  logic              sdi_i,
    input  logic              phase_last_i,
    output logic              start_o,
    output logic              shift_o,
    output logic              report_o,
    output logic              wide_o,
    output logic              rfs_o,
    output logic              cd_o,
    output logic              sclk_o,
    output logic [CHAN_W-1:0] chs_o
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_WIDE  = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0] LAST_SHORT = BIT_W'(SHORT_W - 1);

    seq_state_e        state_q;
    logic [BIT_W-1:0]  bit_q;
    logic              wide_q;
    logic              drop_q;
    logic [CHAN_W-1:0] chs_q;
    pin_set_t          pins;
    logic              chan_diff;
    logic              last_bit;
    logic              publish;

    assign chan_diff = (chan_i != chs_q);
    assign last_bit  = (bit_q == (wide_q ? LAST_WIDE : LAST_SHORT));
    assign start_o   = (state_q == ST_POLL) && run_i && !chan_diff && !sdi_i;
    assign shift_o   = (state_q == ST_HIGH) && phase_last_i;
    assign publish   = (state_q == ST_CLOSE) && phase_last_i;
    assign report_o  = publish && !drop_q;
    assign wide_o    = wide_q;

    assign pins   = pins_for(state_q);
    assign rfs_o  = pins.rfs;
    assign cd_o   = pins.cd;
    assign sclk_o = pins.sclk;
    assign chs_o  = chs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            wide_q  <= 1'b1;
            drop_q  <= 1'b0;
            chs_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (run_i) state_q <= ST_POLL;
                end
                ST_POLL: begin
                    if (!run_i) begin
                        state_q <= ST_IDLE;
                    end else if (chan_diff) begin
                        chs_q  <= chan_i;
                        drop_q <= 1'b1;
                    end else if (!sdi_i) begin
                        state_q <= ST_SEL;
                        wide_q  <= wide_i;
                        bit_q   <= '0;
                    end
                end
                ST_SEL: begin
                    if (phase_last_i) state_q <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (phase_last_i) state_q <= ST_LOW;
                end
                ST_LOW: begin
                    if (phase_last_i) begin
                        if (last_bit) begin
                            state_q <= ST_CLOSE;
                        end else begin
                            bit_q   <= bit_q + BIT_W'(1);
                            state_q <= ST_HIGH;
                        end
                    end
                end
                ST_CLOSE: begin
                    if (phase_last_i) begin
                        state_q <= ST_POLL;
                        drop_q  <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_rfs_low_needs_cd_r4: assert property (@(posedge clk) disable iff (rst)
        !rfs_o |-> cd_o);

    p_sclk_inside_frame_r5: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> !rfs_o);

    p_open_after_ready_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cd_o) |-> ($past(!sdi_i) && $past(rfs_o)));

    p_chan_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        in_frame(state_q) |=> $stable(chs_q));

    p_bit_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (!wide_q && in_frame(state_q)) |-> (bit_q <= LAST_SHORT));

    p_idle_no_frame_r12: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> !cd_o);

endmodule

// File: rtl/sdadc_reader.sv
`timescale 1ns/1ps
module sdadc_reader #(
    parameter int HALF_CYC = 4,
    parameter int WORD_W   = 24,
    parameter int SHORT_W  = 16,
    parameter int CHAN_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              wide_i,
    input  logic              sdi_i,
    output logic              tfs_o,
    output logic              rfs_o,
    output logic              cd_o,
    output logic              sclk_o,
    output logic [CHAN_W-1:0] chs_o,
    output logic [WORD_W-1:0] res_o,
    output logic [CHAN_W-1:0] res_chan_o,
    output logic              res_vld_o
);
    logic              start;
    logic              shift;
    logic              report;
    logic              wide_q;
    logic              phase_last;
    logic [WORD_W-1:0] cap_word;
    logic [WORD_W-1:0] res_q;
    logic [CHAN_W-1:0] res_chan_q;
    logic              vld_q;

    // Writes are handled elsewhere; this side only ever reads.
    assign tfs_o = 1'b1;

    sdadc_phase #(.HALF_CYC(HALF_CYC)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .restart_i (start),
        .last_o    (phase_last)
    );

    sdadc_capture #(.WORD_W(WORD_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (start),
        .shift_i (shift),
        .bit_i   (sdi_i),
        .word_o  (cap_word)
    );

    sdadc_seq #(
        .WORD_W  (WORD_W),
        .SHORT_W (SHORT_W),
        .CHAN_W  (CHAN_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .run_i        (run_i),
        .chan_i       (chan_i),
        .wide_i       (wide_i),
        .sdi_i        (sdi_i),
        .phase_last_i (phase_last),
        .start_o      (start),
        .shift_o      (shift),
        .report_o     (report),
        .wide_o       (wide_q),
        .rfs_o        (rfs_o),
        .cd_o         (cd_o),
        .sclk_o       (sclk_o),
        .chs_o        (chs_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q      <= '0;
            res_chan_q <= '0;
            vld_q      <= 1'b0;
        end else begin
            vld_q <= report;
            if (report) begin
                res_q      <= cap_word;
                res_chan_q <= chs_o;
            end
        end
    end

    assign res_o      = res_q;
    assign res_chan_o = res_chan_q;
    assign res_vld_o  = vld_q;

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
        res_vld_o |=> !res_vld_o);

    p_strobe_after_close_r9: assert property (@(posedge clk) disable iff (rst)
        res_vld_o |-> ($past(cd_o) && !cd_o));

    p_short_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (res_vld_o && !wide_q) |-> (res_o[WORD_W-1:SHORT_W] == '0));

    p_word_held_r11: assert property (@(posedge clk) disable iff (rst)
        !res_vld_o |-> $stable(res_o));

endmodule

// File: tb/test_sdadc_reader.sv
`timescale 1ns/1ps
module test_sdadc_reader;

    localparam int HALF = 2;
    localparam int CAL_CYC = 60;
    localparam int CONV_CYC = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_i = 1'b0;
    logic [2:0]  chan_i = 3'd0;
    logic        wide_i = 1'b1;
    logic        sdi;
    logic        tfs_o, rfs_o, cd_o, sclk_o, res_vld_o;
    logic [2:0]  chs_o, res_chan_o;
    logic [23:0] res_o;

    int n_vec = 0;
    int n_bad = 0;
    bit rst_done = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sdadc_reader #(.HALF_CYC(HALF)) i_sdadc_reader (
        .clk(clk), .rst(rst), .run_i(run_i), .chan_i(chan_i), .wide_i(wide_i),
        .sdi_i(sdi), .tfs_o(tfs_o), .rfs_o(rfs_o), .cd_o(cd_o), .sclk_o(sclk_o),
        .chs_o(chs_o), .res_o(res_o), .res_chan_o(res_chan_o), .res_vld_o(res_vld_o)
    );

    // ---------------- converter model (updates away from the active edge)
    bit          busy = 1'b1;
    int          busy_cnt = CAL_CYC;
    int          bit_idx = 0;
    int          conv_no = 0;
    logic [23:0] conv_word = 24'h5A3C96;
    logic        prev_sclk = 1'b0;
    logic        prev_rfs = 1'b1;

    always @(negedge clk) begin
        if (rst) begin
            busy = 1'b1; busy_cnt = CAL_CYC; bit_idx = 0;
        end else begin
            if (busy) begin
                if (busy_cnt > 0) busy_cnt--; else busy = 1'b0;
            end
            if (prev_sclk && !sclk_o) bit_idx++;
            if (prev_rfs && !rfs_o) bit_idx = 0;
            if (!prev_rfs && rfs_o) begin
                busy = 1'b1; busy_cnt = CONV_CYC; bit_idx = 0;
                conv_no++;
                conv_word = 24'h5A3C96 ^ (24'(conv_no) * 24'h01F3D5);
            end
        end
        prev_sclk = sclk_o;
        prev_rfs  = rfs_o;
    end

    int nb_now;
    always_comb nb_now = wide_i ? 24 : 16;
    assign sdi = busy ? 1'b1 :
                 (rfs_o ? 1'b0 :
                 ((bit_idx < nb_now) ? conv_word[nb_now - 1 - bit_idx] : 1'b1));

    // ---------------- behavioural reference model
    logic        e_rfs = 1'b1, e_cd = 1'b0, e_sclk = 1'b0, e_vld = 1'b0;
    logic [2:0]  e_chs = 3'd0, e_rch = 3'd0;
    logic [23:0] e_res = 24'd0;
    logic        s_run, s_di, s_wide;
    logic [2:0]  s_ch;

    task automatic tick();
        @(posedge clk);
        s_run = run_i; s_di = sdi; s_ch = chan_i; s_wide = wide_i;
        #1;
        e_vld = 1'b0;
    endtask

    initial begin : model
        bit polling = 1'b0;
        bit drop = 1'b0;
        wait (rst_done);
        forever begin
            int nb;
            logic [23:0] acc;
            forever begin
                tick();
                if (!polling) begin
                    if (s_run) polling = 1'b1;
                end else if (!s_run) begin
                    polling = 1'b0;
                end else if (s_ch != e_chs) begin
                    e_chs = s_ch; drop = 1'b1;
                end else if (!s_di) begin
                    break;
                end
            end
            nb = s_wide ? 24 : 16;
            acc = '0;
            e_cd = 1'b1;
            for (int i = 1; i <= HALF; i++) begin
                tick();
                if (i == HALF) begin e_rfs = 1'b0; e_sclk = 1'b1; end
            end
            for (int b = 0; b < nb; b++) begin
                for (int i = 1; i <= HALF; i++) begin
                    tick();
                    if (i == HALF) begin acc = {acc[22:0], s_di}; e_sclk = 1'b0; end
                end
                for (int i = 1; i <= HALF; i++) begin
                    tick();
                    if (i == HALF) begin
                        if (b == nb - 1) e_rfs = 1'b1; else e_sclk = 1'b1;
                    end
                end
            end
            for (int i = 1; i <= HALF; i++) begin
                tick();
                if (i == HALF) begin
                    e_cd = 1'b0;
                    if (!drop) begin e_vld = 1'b1; e_res = acc; e_rch = e_chs; end
                    drop = 1'b0;
                end
            end
        end
    end

    // ---------------- comparison
    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_done && !finished) begin
            check("R2 tfs", 24'(tfs_o), 24'd1);
            check("R3/R7/R12 rfs", 24'(rfs_o), 24'(e_rfs));
            check("R4/R7 cd", 24'(cd_o), 24'(e_cd));
            check("R5 sclk", 24'(sclk_o), 24'(e_sclk));
            check("R10 chs", 24'(chs_o), 24'(e_chs));
            check("R9/R11 vld", 24'(res_vld_o), 24'(e_vld));
            check("R5/R6/R8/R11 word", res_o, e_res);
            check("R9 res chan", 24'(res_chan_o), 24'(e_rch));
        end
    end

    task automatic wait_vld(input int n);
        int seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (res_vld_o) seen++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // ---------------- stimulus
    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rfs", 24'(rfs_o), 24'd1);
        check("R1 tfs", 24'(tfs_o), 24'd1);
        check("R1 cd", 24'(cd_o), 24'd0);
        check("R1 sclk", 24'(sclk_o), 24'd0);
        check("R1 chs", 24'(chs_o), 24'd0);
        check("R1 vld", 24'(res_vld_o), 24'd0);
        rst = 1'b0;
        rst_done = 1'b1;
        // R12: idle with run low, no frame during and after calibration
        repeat (80) @(negedge clk);
        run_i = 1'b1;
        // R3/R5/R6: 24-bit frames after calibration completes
        wait_vld(3);
        // R6/R8: 16-bit frames, toggling wide_i mid-frame
        wide_i = 1'b0;
        wait_vld(1);
        @(negedge clk);
        wait (!rfs_o);
        wide_i = 1'b1;
        repeat (7) @(negedge clk);
        wide_i = 1'b0;
        wait_vld(2);
        // R10/R11: single channel change, first result dropped
        chan_i = 3'd5;
        wait_vld(2);
        // R11: two changes before one frame
        chan_i = 3'd3;
        repeat (3) @(negedge clk);
        chan_i = 3'd7;
        wide_i = 1'b1;
        wait_vld(2);
        // R12: stop and restart
        wait (rfs_o && !cd_o);
        run_i = 1'b0;
        repeat (120) @(negedge clk);
        run_i = 1'b1;
        wait_vld(2);
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule